// File: doc/BRIEF.md
# Snoop Coherence Tag-Status Controller

This block keeps the coherence status of every line of a direct-mapped backup cache and updates it for two streams of work: requests from the local processor and transactions snooped from the shared bus. Each line's entry holds its address tag and three status flags: Valid (the slot is occupied), Shared (another cache may hold a copy) and Dirty (the line is newer than memory). The flags are stored with an odd-parity bit, and the parity is checked every time an entry is read.

The policy is write-invalidate. A snooped read that hits marks the line Shared and raises a shared response. If the line was Dirty it also raises a data-supply response and cleans the line. A snooped write that hits invalidates the line. A local write to a Shared line asks for a write-through to memory and an invalidate broadcast, and keeps the line as the only valid copy. A local miss asks for a fill, preceded by a victim writeback when the old occupant is Dirty. The data array, bus arbitration and memory are outside the block; it only emits the action pulses.

After reset the block clears its status store one entry per cycle and holds `req_rdy_o` low meanwhile. Every accepted operation produces its registered result two clock cycles after the cycle in which it was presented.

Top module: `coh_tag_ctrl`

## Requirements
- R1: While reset is high and for DEPTH-1 sampled cycles after it falls, `req_rdy_o` is 0 and no result pulse is raised. After that every line reads as invalid, so a first local read misses with `fill_req_o`=1 and `wb_req_o`=0.
- R2: Status is stored with odd parity over {V,S,D,P}. When a local write is made with `lcl_inj_i`=1, the parity written is wrong. A later access to that line raises `par_err_o` and treats the line as invalid: a local access misses without a writeback, and a snoop gives no response. The refill that follows stores correct parity.
- R3: A snooped read that hits a valid line raises `snp_shared_o` and leaves the line Shared.
- R4: A snooped read that hits a Dirty line also raises `snp_supply_o` (never without `snp_shared_o`). The line is left valid, Shared and clean, so a second snooped read gives shared without supply.
- R5: A snooped write that hits invalidates the line with no response. A later local access to it misses without a writeback.
- R6: A local write that hits a valid, non-Shared line sets Dirty and raises none of `fill_req_o`, `wb_req_o` or `wt_inv_o`.
- R7: A local write that hits a Shared line raises `wt_inv_o`. The line stays valid, non-Shared and clean.
- R8: A local miss raises `fill_req_o`. If the displaced line is valid and Dirty, it also raises `wb_req_o` with `wb_addr_o` = {old tag, index}. A read fill sets Valid and copies `lcl_shr_i` into Shared.
- R9: A local write miss allocates the line. If `lcl_shr_i` is 1 it raises `wt_inv_o` and leaves the line clean and non-Shared; otherwise it leaves the line Dirty.
- R10: When a snoop and a local request arrive in the same cycle, the snoop is processed first. The local request is held and `req_rdy_o` is 0 in the following cycle.
- R11: Results appear two cycles after the request cycle. Local results raise `lcl_done_o`, and `lcl_hit_o` tells a hit from a miss.
- R12: A snoop that misses (invalid line or different tag) raises no response and changes no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcl_req_i | input | 1 | Local request strobe, taken when `req_rdy_o` is 1 |
| lcl_wr_i | input | 1 | 1 = local write, 0 = local read |
| lcl_shr_i | input | 1 | Shared response seen on the bus for this request's fill |
| lcl_inj_i | input | 1 | Store the status of this local write with wrong parity |
| lcl_addr_i | input | AW | Local line address {tag, index} |
| req_rdy_o | output | 1 | Local request can be accepted |
| snp_req_i | input | 1 | Snooped bus transaction strobe |
| snp_wr_i | input | 1 | 1 = snooped write, 0 = snooped read |
| snp_addr_i | input | AW | Snooped line address {tag, index} |
| snp_shared_o | output | 1 | Snoop hit: line is held here |
| snp_supply_o | output | 1 | Snoop hit a Dirty line: this cache supplies data |
| lcl_done_o | output | 1 | Result of a local request is on the outputs |
| lcl_hit_o | output | 1 | Local request hit |
| fill_req_o | output | 1 | Fetch the requested line |
| wb_req_o | output | 1 | Write back the displaced Dirty line first |
| wb_addr_o | output | AW | Address of the displaced line |
| wt_inv_o | output | 1 | Write through to memory and invalidate other copies |
| req_addr_o | output | AW | Address of the operation whose result is shown |
| par_err_o | output | 1 | Status parity mismatch on the entry read |

## Verification
The status transitions are driven with local reads and writes whose bus shared input is set or clear. The later result on the same line shows which of Shared and Dirty was stored: a silent write means not Shared, a supply response means Dirty. Snoops with a matching tag and with a different tag at the same index separate a real hit from an index-only match. A conflicting-tag local read then shows whether a victim was left Dirty. The same-cycle snoop and local write to one clean line tells the two orderings apart: with the snoop first, the write must raise a write-through; with the local write first, the snoop would see a Dirty line. Parity injection shows that a corrupted entry is treated as invalid and that the refill repairs it.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef struct packed {
    logic v;
    logic s;
    logic d;
    logic p;
  } stat_t;

  localparam int STAT_W = 4;

  // Build a status word with odd parity; flip inverts the parity bit.
  function automatic stat_t mk_stat(input logic v, input logic s,
                                    input logic d, input logic flip);
    stat_t r;
    r.v = v;
    r.s = s;
    r.d = d;
    r.p = ~(v ^ s ^ d) ^ flip;
    return r;
  endfunction

  function automatic logic stat_bad(input stat_t x);
    return ~(x.v ^ x.s ^ x.d ^ x.p);
  endfunction
endpackage

// File: rtl/coh_stat_ram.sv
module coh_stat_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 13,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Read-first synchronous port pair, suitable for block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/coh_arb.sv
module coh_arb #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          lcl_req,
  input  logic          lcl_wr,
  input  logic          lcl_shr,
  input  logic          lcl_inj,
  input  logic [AW-1:0] lcl_addr,
  input  logic          snp_req,
  input  logic          snp_wr,
  input  logic [AW-1:0] snp_addr,
  output logic          rdy,
  output logic          sel_vld,
  output logic          sel_snp,
  output logic          sel_wr,
  output logic          sel_shr,
  output logic          sel_inj,
  output logic [AW-1:0] sel_addr
);
  logic          hold_v;
  logic          hold_wr;
  logic          hold_shr;
  logic          hold_inj;
  logic [AW-1:0] hold_addr;
  logic          take_lcl;

  assign rdy      = en & ~hold_v;
  assign take_lcl = lcl_req & rdy;

  // Snoop wins; a held local request goes next; a fresh one after that.
  always_comb begin
    sel_vld  = 1'b0;
    sel_snp  = 1'b0;
    sel_wr   = 1'b0;
    sel_shr  = 1'b0;
    sel_inj  = 1'b0;
    sel_addr = snp_addr;
    if (en && snp_req) begin
      sel_vld = 1'b1;
      sel_snp = 1'b1;
      sel_wr  = snp_wr;
    end else if (hold_v) begin
      sel_vld  = 1'b1;
      sel_wr   = hold_wr;
      sel_shr  = hold_shr;
      sel_inj  = hold_inj;
      sel_addr = hold_addr;
    end else if (take_lcl) begin
      sel_vld  = 1'b1;
      sel_wr   = lcl_wr;
      sel_shr  = lcl_shr;
      sel_inj  = lcl_inj;
      sel_addr = lcl_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_wr   <= 1'b0;
      hold_shr  <= 1'b0;
      hold_inj  <= 1'b0;
      hold_addr <= '0;
    end else if (hold_v) begin
      if (!snp_req) hold_v <= 1'b0;
    end else if (take_lcl && snp_req) begin
      hold_v    <= 1'b1;
      hold_wr   <= lcl_wr;
      hold_shr  <= lcl_shr;
      hold_inj  <= lcl_inj;
      hold_addr <= lcl_addr;
    end
  end
endmodule

// File: rtl/coh_next.sv
module coh_next
  import coh_pkg::*;
#(
  parameter int TW = 9
) (
  input  logic          op_snp,
  input  logic          op_wr,
  input  logic          op_shr,
  input  logic          op_inj,
  input  logic [TW-1:0] op_tag,
  input  logic [TW-1:0] ent_tag,
  input  stat_t         ent_stat,
  output logic          we,
  output stat_t         new_stat,
  output logic          hit,
  output logic          perr,
  output logic          rsp_shr,
  output logic          rsp_sup,
  output logic          wb,
  output logic          fill,
  output logic          wt
);
  logic live;

  always_comb begin
    we       = 1'b0;
    new_stat = ent_stat;
    rsp_shr  = 1'b0;
    rsp_sup  = 1'b0;
    wb       = 1'b0;
    fill     = 1'b0;
    wt       = 1'b0;
    perr     = stat_bad(ent_stat);
    live     = ent_stat.v & ~perr;
    hit      = live && (ent_tag == op_tag);
    if (op_snp) begin
      if (hit) begin
        we = 1'b1;
        if (op_wr) begin
          new_stat = mk_stat(1'b0, 1'b0, 1'b0, 1'b0);
        end else begin
          rsp_shr  = 1'b1;
          rsp_sup  = ent_stat.d;
          new_stat = mk_stat(1'b1, 1'b1, 1'b0, 1'b0);
        end
      end
    end else if (hit) begin
      if (op_wr) begin
        we = 1'b1;
        if (ent_stat.s) begin
          wt       = 1'b1;
          new_stat = mk_stat(1'b1, 1'b0, 1'b0, op_inj);
        end else begin
          new_stat = mk_stat(1'b1, 1'b0, 1'b1, op_inj);
        end
      end
    end else begin
      we   = 1'b1;
      fill = 1'b1;
      wb   = live & ent_stat.d;
      if (!op_wr) begin
        new_stat = mk_stat(1'b1, op_shr, 1'b0, op_inj);
      end else if (op_shr) begin
        wt       = 1'b1;
        new_stat = mk_stat(1'b1, 1'b0, 1'b0, op_inj);
      end else begin
        new_stat = mk_stat(1'b1, 1'b0, 1'b1, op_inj);
      end
    end
  end
endmodule

// File: rtl/coh_tag_ctrl.sv
module coh_tag_ctrl
  import coh_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lcl_req_i,
  input  logic          lcl_wr_i,
  input  logic          lcl_shr_i,
  input  logic          lcl_inj_i,
  input  logic [AW-1:0] lcl_addr_i,
  output logic          req_rdy_o,
  input  logic          snp_req_i,
  input  logic          snp_wr_i,
  input  logic [AW-1:0] snp_addr_i,
  output logic          snp_shared_o,
  output logic          snp_supply_o,
  output logic          lcl_done_o,
  output logic          lcl_hit_o,
  output logic          fill_req_o,
  output logic          wb_req_o,
  output logic [AW-1:0] wb_addr_o,
  output logic          wt_inv_o,
  output logic [AW-1:0] req_addr_o,
  output logic          par_err_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int TW = AW - IW;
  localparam int EW = TW + STAT_W;

  // Reset sweep over the status store.
  logic          init_act;
  logic [IW-1:0] init_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_act <= 1'b1;
      init_idx <= '0;
    end else if (init_act) begin
      init_idx <= init_idx + 1'b1;
      if (init_idx == IW'(DEPTH - 1)) init_act <= 1'b0;
    end
  end

  // Selection stage.
  logic          sel_vld, sel_snp, sel_wr, sel_shr, sel_inj;
  logic [AW-1:0] sel_addr;

  coh_arb #(.AW(AW)) i_arb (
    .clk      (clk),
    .rst      (rst),
    .en       (~init_act),
    .lcl_req  (lcl_req_i),
    .lcl_wr   (lcl_wr_i),
    .lcl_shr  (lcl_shr_i),
    .lcl_inj  (lcl_inj_i),
    .lcl_addr (lcl_addr_i),
    .snp_req  (snp_req_i),
    .snp_wr   (snp_wr_i),
    .snp_addr (snp_addr_i),
    .rdy      (req_rdy_o),
    .sel_vld  (sel_vld),
    .sel_snp  (sel_snp),
    .sel_wr   (sel_wr),
    .sel_shr  (sel_shr),
    .sel_inj  (sel_inj),
    .sel_addr (sel_addr)
  );

  // Status store.
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [EW-1:0] wr_data;
  logic [EW-1:0] ram_rdata;

  coh_stat_ram #(.DEPTH(DEPTH), .W(EW)) i_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (sel_addr[IW-1:0]),
    .rdata (ram_rdata)
  );

  // Lookup stage registers.
  logic          s1_v, s1_snp, s1_wr, s1_shr, s1_inj;
  logic [AW-1:0] s1_addr;
  logic [IW-1:0] s1_idx;
  logic [TW-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_snp  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_shr  <= 1'b0;
      s1_inj  <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_v    <= sel_vld;
      s1_snp  <= sel_snp;
      s1_wr   <= sel_wr;
      s1_shr  <= sel_shr;
      s1_inj  <= sel_inj;
      s1_addr <= sel_addr;
    end
  end

  assign s1_idx = s1_addr[IW-1:0];
  assign s1_tag = s1_addr[AW-1:IW];

  // Forward the entry written on the previous edge (read-first RAM).
  logic          lw_v;
  logic [IW-1:0] lw_idx;
  logic [EW-1:0] lw_data;
  logic [EW-1:0] ent;
  logic [TW-1:0] ent_tag;
  stat_t         ent_stat;

  always_ff @(posedge clk) begin
    if (rst) begin
      lw_v    <= 1'b0;
      lw_idx  <= '0;
      lw_data <= '0;
    end else begin
      lw_v    <= wr_en;
      lw_idx  <= wr_idx;
      lw_data <= wr_data;
    end
  end

  assign ent      = (lw_v && (lw_idx == s1_idx)) ? lw_data : ram_rdata;
  assign ent_tag  = ent[EW-1:STAT_W];
  assign ent_stat = stat_t'(ent[STAT_W-1:0]);

  // Decision logic.
  logic  nx_we, nx_hit, nx_perr, nx_shr, nx_sup, nx_wb, nx_fill, nx_wt;
  stat_t nx_stat;

  coh_next #(.TW(TW)) i_next (
    .op_snp   (s1_snp),
    .op_wr    (s1_wr),
    .op_shr   (s1_shr),
    .op_inj   (s1_inj),
    .op_tag   (s1_tag),
    .ent_tag  (ent_tag),
    .ent_stat (ent_stat),
    .we       (nx_we),
    .new_stat (nx_stat),
    .hit      (nx_hit),
    .perr     (nx_perr),
    .rsp_shr  (nx_shr),
    .rsp_sup  (nx_sup),
    .wb       (nx_wb),
    .fill     (nx_fill),
    .wt       (nx_wt)
  );

  assign wr_en   = init_act | (s1_v & nx_we);
  assign wr_idx  = init_act ? init_idx : s1_idx;
  assign wr_data = init_act ? {TW'(0), mk_stat(1'b0, 1'b0, 1'b0, 1'b0)}
                            : {s1_tag, nx_stat};

  // Registered results.
  logic lcl_op;
  assign lcl_op = s1_v & ~s1_snp;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared_o <= 1'b0;
      snp_supply_o <= 1'b0;
      lcl_done_o   <= 1'b0;
      lcl_hit_o    <= 1'b0;
      fill_req_o   <= 1'b0;
      wb_req_o     <= 1'b0;
      wb_addr_o    <= '0;
      wt_inv_o     <= 1'b0;
      req_addr_o   <= '0;
      par_err_o    <= 1'b0;
    end else begin
      snp_shared_o <= s1_v & s1_snp & nx_shr;
      snp_supply_o <= s1_v & s1_snp & nx_sup;
      lcl_done_o   <= lcl_op;
      lcl_hit_o    <= lcl_op & nx_hit;
      fill_req_o   <= lcl_op & nx_fill;
      wb_req_o     <= lcl_op & nx_wb;
      wb_addr_o    <= {ent_tag, s1_idx};
      wt_inv_o     <= lcl_op & nx_wt;
      req_addr_o   <= s1_addr;
      par_err_o    <= s1_v & nx_perr;
    end
  end
endmodule

// File: rtl/coh_tag_ctrl_chk.sv
module coh_tag_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic lcl_req_i,
  input logic snp_req_i,
  input logic req_rdy_o,
  input logic snp_shared_o,
  input logic snp_supply_o,
  input logic lcl_done_o,
  input logic lcl_hit_o,
  input logic fill_req_o,
  input logic wb_req_o,
  input logic wt_inv_o
);
  AST_SUPPLY_NEEDS_SHARED: assert property (@(posedge clk) disable iff (rst)
    snp_supply_o |-> snp_shared_o); // R4

  AST_WB_NEEDS_FILL: assert property (@(posedge clk) disable iff (rst)
    wb_req_o |-> fill_req_o); // R8

  AST_HIT_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    lcl_hit_o |-> !fill_req_o && !wb_req_o); // R8

  AST_ACTIONS_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (fill_req_o || wt_inv_o || lcl_hit_o) |-> lcl_done_o); // R11

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(lcl_done_o && snp_shared_o)); // R10

  AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (lcl_req_i && req_rdy_o && snp_req_i) |=> !req_rdy_o); // R10

  AST_INIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !req_rdy_o); // R1
endmodule

bind coh_tag_ctrl coh_tag_ctrl_chk i_chk (
  .clk          (clk),
  .rst          (rst),
  .lcl_req_i    (lcl_req_i),
  .snp_req_i    (snp_req_i),
  .req_rdy_o    (req_rdy_o),
  .snp_shared_o (snp_shared_o),
  .snp_supply_o (snp_supply_o),
  .lcl_done_o   (lcl_done_o),
  .lcl_hit_o    (lcl_hit_o),
  .fill_req_o   (fill_req_o),
  .wb_req_o     (wb_req_o),
  .wt_inv_o     (wt_inv_o)
);

// File: tb/test_coh_tag_ctrl.sv
module test_coh_tag_ctrl;
  localparam int DEPTH = 8;
  localparam int AW    = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lcl_req_i = 1'b0, lcl_wr_i = 1'b0, lcl_shr_i = 1'b0, lcl_inj_i = 1'b0;
  logic [AW-1:0] lcl_addr_i = '0;
  logic          snp_req_i = 1'b0, snp_wr_i = 1'b0;
  logic [AW-1:0] snp_addr_i = '0;
  logic          req_rdy_o, snp_shared_o, snp_supply_o, lcl_done_o, lcl_hit_o;
  logic          fill_req_o, wb_req_o, wt_inv_o, par_err_o;
  logic [AW-1:0] wb_addr_o, req_addr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  coh_tag_ctrl #(.DEPTH(DEPTH), .AW(AW)) i_coh_tag_ctrl (.*);

  // Captured results.
  logic c_shr, c_sup, c_done, c_hit, c_fill, c_wb, c_wt, c_perr, e_done;
  logic [AW-1:0] c_wba;

  function automatic logic [AW-1:0] mk_addr(input int tag, input int idx);
    return AW'(tag * DEPTH + idx);
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic grab();
    c_shr  = snp_shared_o;
    c_sup  = snp_supply_o;
    c_done = lcl_done_o;
    c_hit  = lcl_hit_o;
    c_fill = fill_req_o;
    c_wb   = wb_req_o;
    c_wt   = wt_inv_o;
    c_perr = par_err_o;
    c_wba  = wb_addr_o;
  endtask

  task automatic lcl(input logic wr, input logic [AW-1:0] a,
                     input logic shr, input logic inj);
    while (!req_rdy_o) @(negedge clk);
    lcl_req_i = 1'b1; lcl_wr_i = wr; lcl_addr_i = a;
    lcl_shr_i = shr;  lcl_inj_i = inj;
    @(posedge clk); @(negedge clk);
    e_done = lcl_done_o;
    lcl_req_i = 1'b0; lcl_inj_i = 1'b0;
    @(posedge clk); @(negedge clk);
    grab();
  endtask

  task automatic snp(input logic wr, input logic [AW-1:0] a);
    snp_req_i = 1'b1; snp_wr_i = wr; snp_addr_i = a;
    @(posedge clk); @(negedge clk);
    snp_req_i = 1'b0;
    @(posedge clk); @(negedge clk);
    grab();
  endtask

  task automatic t_reset();
    int cnt;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", req_rdy_o, 0);
    chk("R1", "done in reset", lcl_done_o, 0);
    chk("R1", "shared in reset", snp_shared_o, 0);
    rst = 1'b0;
    cnt = 0;
    @(negedge clk);
    while (!req_rdy_o && cnt < 100) begin
      cnt++;
      @(negedge clk);
    end
    chk("R1", "sweep cycles", cnt, DEPTH - 1);
    lcl(1'b0, mk_addr(5, 0), 1'b0, 1'b0);
    chk("R11", "no early result", e_done, 0);
    chk("R11", "done", c_done, 1);
    chk("R1", "first read hit", c_hit, 0);
    chk("R1", "first read fill", c_fill, 1);
    chk("R1", "first read wb", c_wb, 0);
  endtask

  task automatic t_silent_and_victim();
    lcl(1'b1, mk_addr(6, 2), 1'b0, 1'b0);
    chk("R9", "wr miss fill", c_fill, 1);
    chk("R9", "wr miss unshared no wt", c_wt, 0);
    lcl(1'b1, mk_addr(6, 2), 1'b0, 1'b0);
    chk("R6", "wr hit", c_hit, 1);
    chk("R6", "wr hit traffic", {c_fill, c_wb, c_wt}, 3'b000);
    lcl(1'b0, mk_addr(7, 2), 1'b0, 1'b0);
    chk("R8", "victim wb", c_wb, 1);
    chk("R8", "victim addr", c_wba, mk_addr(6, 2));
    chk("R8", "victim fill", c_fill, 1);
    lcl(1'b1, mk_addr(7, 2), 1'b0, 1'b0);
    chk("R8", "clean fill unshared", {c_hit, c_wt}, 2'b10);
  endtask

  task automatic t_fill_shared();
    lcl(1'b0, mk_addr(2, 1), 1'b1, 1'b0);
    chk("R8", "read fill", c_fill, 1);
    lcl(1'b1, mk_addr(2, 1), 1'b0, 1'b0);
    chk("R7", "shared wr hit", c_hit, 1);
    chk("R7", "shared wr wt", c_wt, 1);
    lcl(1'b1, mk_addr(2, 1), 1'b0, 1'b0);
    chk("R7", "after wt silent", {c_hit, c_wt, c_fill}, 3'b100);
    snp(1'b0, mk_addr(2, 1));
    chk("R6", "dirty seen by snoop", c_sup, 1);
  endtask

  task automatic t_snoops();
    lcl(1'b1, mk_addr(2, 3), 1'b0, 1'b0);
    snp(1'b0, mk_addr(2, 3));
    chk("R3", "snoop rd shared", c_shr, 1);
    chk("R4", "snoop rd dirty supply", c_sup, 1);
    snp(1'b0, mk_addr(2, 3));
    chk("R4", "second snoop shared", c_shr, 1);
    chk("R4", "second snoop cleaned", c_sup, 0);
    lcl(1'b1, mk_addr(2, 3), 1'b0, 1'b0);
    chk("R3", "line shared after snoop", {c_hit, c_wt}, 2'b11);
    snp(1'b1, mk_addr(2, 3));
    chk("R5", "snoop wr no response", {c_shr, c_sup}, 2'b00);
    lcl(1'b0, mk_addr(2, 3), 1'b0, 1'b0);
    chk("R5", "after invalidate miss", {c_hit, c_fill, c_wb}, 3'b010);
  endtask

  task automatic t_snoop_miss();
    lcl(1'b1, mk_addr(4, 4), 1'b0, 1'b0);
    snp(1'b0, mk_addr(9, 4));
    chk("R12", "tag miss rd", {c_shr, c_sup}, 2'b00);
    snp(1'b1, mk_addr(9, 4));
    chk("R12", "tag miss wr", {c_shr, c_sup}, 2'b00);
    lcl(1'b0, mk_addr(1, 4), 1'b0, 1'b0);
    chk("R12", "line kept dirty", c_wb, 1);
    chk("R12", "kept victim addr", c_wba, mk_addr(4, 4));
  endtask

  task automatic t_parity();
    lcl(1'b1, mk_addr(3, 5), 1'b0, 1'b1);
    chk("R2", "inj write no error yet", c_perr, 0);
    lcl(1'b0, mk_addr(3, 5), 1'b0, 1'b0);
    chk("R2", "parity error", c_perr, 1);
    chk("R2", "treated invalid", {c_hit, c_fill, c_wb}, 3'b010);
    lcl(1'b0, mk_addr(3, 5), 1'b0, 1'b0);
    chk("R2", "repaired", {c_perr, c_hit}, 2'b01);
    lcl(1'b1, mk_addr(3, 5), 1'b0, 1'b1);
    snp(1'b0, mk_addr(3, 5));
    chk("R2", "snoop parity error", c_perr, 1);
    chk("R2", "snoop on bad entry", {c_shr, c_sup}, 2'b00);
  endtask

  task automatic t_wr_miss_shared();
    lcl(1'b1, mk_addr(8, 6), 1'b1, 1'b0);
    chk("R9", "shared wr miss", {c_fill, c_wt}, 2'b11);
    lcl(1'b1, mk_addr(8, 6), 1'b0, 1'b0);
    chk("R9", "then silent", {c_hit, c_wt}, 2'b10);
    snp(1'b0, mk_addr(8, 6));
    chk("R9", "dirty after silent wr", c_sup, 1);
  endtask

  task automatic t_collide();
    lcl(1'b0, mk_addr(3, 7), 1'b0, 1'b0);
    snp_req_i = 1'b1; snp_wr_i = 1'b0; snp_addr_i = mk_addr(3, 7);
    lcl_req_i = 1'b1; lcl_wr_i = 1'b1; lcl_addr_i = mk_addr(3, 7); lcl_shr_i = 1'b0;
    @(posedge clk); @(negedge clk);
    snp_req_i = 1'b0; lcl_req_i = 1'b0;
    chk("R10", "held local blocks ready", req_rdy_o, 0);
    @(posedge clk); @(negedge clk);
    grab();
    chk("R10", "snoop first shared", c_shr, 1);
    chk("R10", "snoop first no supply", c_sup, 0);
    chk("R10", "local not yet", c_done, 0);
    @(posedge clk); @(negedge clk);
    grab();
    chk("R10", "local after snoop", c_done, 1);
    chk("R10", "local sees shared", {c_hit, c_wt}, 2'b11);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_silent_and_victim();
    t_fill_shared();
    t_snoops();
    t_snoop_miss();
    t_parity();
    t_wr_miss_shared();
    t_collide();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule